// File: doc/BRIEF.md
# Video Data Simulation Source

This block stands in front of the acquisition FIFO of a multi-channel detector front-end, at the point where the ADC words would normally arrive. It lets the data path be checked without a real sensor attached. A two-bit setting written by software picks what the block sends. It can pass the real converter words through. It can also replace them with one of two synthetic patterns: the channel's own number, or a counter that steps once per conversion.

Each conversion strobe that arrives while the block is idle starts one group. At that strobe edge the block captures the mode, the ADC words and the counter value. It then sends one sample per channel on consecutive cycles, lowest channel first. Each sample carries a valid flag, the channel index and the data word. Because the capture happens only at the strobe, one group never mixes two modes or two sets of converter words.

Top module: `vsim_source`

## Requirements
- R1: After reset, `smp_valid` is low, and the first counter-mode group shows the value zero.
- R2: A strobe that arrives while idle starts a group. In each of the next NCH cycles the block outputs one sample with `smp_valid` high, and `smp_chan` runs 0, 1, …, NCH-1. After that, `smp_valid` goes low.
- R3: With mode code 2'b00, the data of channel c is bits [c*DATA_W +: DATA_W] of `adc_words`, as they stood at the accepting strobe edge. Later changes to `adc_words` do not alter the group.
- R4: With mode code 2'b01, the data of every sample equals its channel index, zero-extended.
- R5: With mode code 2'b10, every sample of a group carries the same CNT_W-bit counter value, zero-extended. A group started with code 2'b01 or 2'b10 advances the counter by one.
- R6: After the counter reaches 2^CNT_W-1, the next advance returns it to zero.
- R7: A group started with a pass-through code leaves the counter value unchanged.
- R8: Mode code 2'b11 behaves exactly like 2'b00. It passes the ADC words through and leaves the counter unchanged.
- R9: A change of `sim_mode` or `adc_words` while a group is being sent has no effect on that group.
- R10: A strobe that arrives while a group is being sent is ignored. It adds no samples and does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_strobe | input | 1 | Conversion strobe; starts a group when the block is idle |
| sim_mode | input | 2 | Source select: 00 ADC, 01 channel number, 10 counter, 11 ADC |
| adc_words | input | NCH*DATA_W | Real converter words, channel c in bits [c*DATA_W +: DATA_W] |
| smp_valid | output | 1 | High for each emitted sample |
| smp_chan | output | IDX_W | Channel index of the current sample |
| smp_data | output | DATA_W | Sample data word |

## Verification
Pass-through groups use a different ADC word on each lane, so a swapped or misindexed lane stands out. Channel-number groups show whether the index and the data stay aligned. Counter groups are run back to back, after pass-through and reserved-code groups, and through a full wrap of a narrow counter. This separates "advances" from "holds" and also shows the wrap to zero. Some groups are disturbed in the middle, either by a new mode and new ADC words or by an extra strobe. These show that the group is captured at the strobe and that a busy strobe is dropped.

// File: rtl/vsim_pkg.sv
package vsim_pkg;

    typedef enum logic [1:0] {
        VM_ADC   = 2'b00,
        VM_CHID  = 2'b01,
        VM_COUNT = 2'b10,
        VM_RSVD  = 2'b11
    } vsim_mode_e;

    typedef struct packed {
        logic accept;
        logic busy;
    } vsim_ctl_t;

    function automatic vsim_mode_e vsim_resolve(input logic [1:0] raw);
        vsim_mode_e m;
        case (raw)
            2'b01:   m = VM_CHID;
            2'b10:   m = VM_COUNT;
            default: m = VM_ADC;
        endcase
        return m;
    endfunction

    function automatic logic vsim_is_sim(input vsim_mode_e m);
        return (m == VM_CHID) || (m == VM_COUNT);
    endfunction

endpackage

// File: rtl/vsim_counter.sv
module vsim_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/vsim_sequencer.sv
module vsim_sequencer
    import vsim_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    output vsim_ctl_t        ctl,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCH - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;
    logic             last;

    assign accept = strobe && !busy_q;
    assign last   = busy_q && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign ctl.accept = accept;
    assign ctl.busy   = busy_q;
    assign idx        = idx_q;

    AST_GROUP_START: assert property (@(posedge clk) disable iff (rst)
        (strobe && !busy_q) |=> (busy_q && idx_q == '0)); // R2

    AST_GROUP_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q != LAST_IDX) |=> (busy_q && idx_q == IDX_W'($past(idx_q) + 1'b1))); // R2

    AST_BUSY_STROBE_DROP: assert property (@(posedge clk) disable iff (rst)
        (busy_q && strobe) |=> (!busy_q || idx_q != '0)); // R10

endmodule

// File: rtl/vsim_pattern.sv
module vsim_pattern
    import vsim_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  vsim_ctl_t             ctl,
    input  logic [1:0]            mode_raw,
    input  logic [NCH*DATA_W-1:0] adc_flat,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [IDX_W-1:0]      idx,
    output logic [DATA_W-1:0]     data
);

    logic [DATA_W-1:0] lane_in [NCH];
    logic [DATA_W-1:0] lane_q  [NCH];
    vsim_mode_e        mode_q;
    logic [CNT_W-1:0]  snap_q;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign lane_in[c] = adc_flat[c*DATA_W +: DATA_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[c] <= '0;
            end else if (ctl.accept) begin
                lane_q[c] <= lane_in[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= VM_ADC;
            snap_q <= '0;
        end else if (ctl.accept) begin
            mode_q <= vsim_resolve(mode_raw);
            snap_q <= cnt;
        end
    end

    always_comb begin
        case (mode_q)
            VM_CHID:  data = DATA_W'(idx);
            VM_COUNT: data = DATA_W'(snap_q);
            default:  data = lane_q[idx];
        endcase
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ctl.busy && !ctl.accept) |=> $stable(mode_q)); // R9

    AST_CHID_MATCH: assert property (@(posedge clk) disable iff (rst)
        (ctl.busy && mode_q == VM_CHID) |-> (data == DATA_W'(idx))); // R4

    AST_NO_RSVD_LATCH: assert property (@(posedge clk) disable iff (rst)
        ctl.busy |-> (mode_q != VM_RSVD)); // R8

endmodule

// File: rtl/vsim_source.sv
module vsim_source
    import vsim_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = DATA_W,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  conv_strobe,
    input  logic [1:0]            sim_mode,
    input  logic [NCH*DATA_W-1:0] adc_words,
    output logic                  smp_valid,
    output logic [IDX_W-1:0]      smp_chan,
    output logic [DATA_W-1:0]     smp_data
);

    vsim_ctl_t        ctl;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             cnt_en;

    assign cnt_en = ctl.accept && vsim_is_sim(vsim_resolve(sim_mode));

    vsim_sequencer #(
        .NCH   (NCH),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .strobe (conv_strobe),
        .ctl    (ctl),
        .idx    (idx)
    );

    vsim_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .en  (cnt_en),
        .cnt (cnt)
    );

    vsim_pattern #(
        .NCH    (NCH),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_pat (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .mode_raw (sim_mode),
        .adc_flat (adc_words),
        .cnt      (cnt),
        .idx      (idx),
        .data     (smp_data)
    );

    assign smp_valid = ctl.busy;
    assign smp_chan  = idx;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !conv_strobe) |=> !smp_valid); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !smp_valid); // R1

endmodule

// File: tb/vsim_source_tb.sv
`timescale 1ns/1ps
module vsim_source_tb;

    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int CW  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              conv = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic [NCH*DW-1:0] adc = '0;
    logic              valid;
    logic [1:0]        chan;
    logic [DW-1:0]     data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [CW-1:0] cnt_m = '0;

    always #10 clk = ~clk;

    vsim_source #(.NCH(NCH), .DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .conv_strobe (conv),
        .sim_mode    (mode),
        .adc_words   (adc),
        .smp_valid   (valid),
        .smp_chan    (chan),
        .smp_data    (data)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic load_adc(input logic [DW-1:0] base);
        for (int c = 0; c < NCH; c++) adc[c*DW +: DW] = base + DW'(c * 16'h0111);
    endtask

    // poke: 0 none, 1 new mode and ADC words mid-group, 2 extra strobe mid-group
    task automatic run_group(input logic [1:0] m, input string req, input int poke);
        logic [NCH*DW-1:0] snap;
        logic [DW-1:0]     e;
        mode = m;
        snap = adc;
        conv = 1'b1;
        @(negedge clk);
        conv = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            case (m)
                2'b01:   e = DW'(i);
                2'b10:   e = DW'(cnt_m);
                default: e = snap[i*DW +: DW];
            endcase
            chk({req, " R2 valid"}, 32'(valid), 32'd1);
            chk({req, " R2 chan"}, 32'(chan), 32'(i));
            chk({req, " data"}, 32'(data), 32'(e));
            if (i == 1 && poke == 1) begin
                mode = (m == 2'b10) ? 2'b01 : 2'b10;
                adc  = ~adc;
            end
            if (i == 1 && poke == 2) conv = 1'b1;
            if (i == 2) conv = 1'b0;
            @(negedge clk);
        end
        chk({req, " R2 end"}, 32'(valid), 32'd0);
        if (m == 2'b01 || m == 2'b10) cnt_m = cnt_m + 1'b1;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            chk("R1 valid low after reset", 32'(valid), 32'd0);
            @(negedge clk);
        end
        run_group(2'b10, "R1 first count", 0);
        run_group(2'b10, "R5 count step", 0);
    endtask

    task automatic t_adc();
        load_adc(16'hA000);
        run_group(2'b00, "R3 pass-through", 1);
        run_group(2'b10, "R7 hold after pass", 0);
    endtask

    task automatic t_rsvd();
        load_adc(16'h3C05);
        run_group(2'b11, "R8 reserved code", 0);
        run_group(2'b10, "R8 hold after reserved", 0);
    endtask

    task automatic t_ident();
        run_group(2'b01, "R4 channel number", 0);
        run_group(2'b10, "R5 advance after ident", 0);
    endtask

    task automatic t_midchange();
        load_adc(16'h5A00);
        run_group(2'b01, "R9 mid-group change", 1);
        run_group(2'b10, "R9 next group", 0);
    endtask

    task automatic t_busy();
        run_group(2'b10, "R10 busy strobe", 2);
        for (int k = 0; k < 3; k++) begin
            chk("R10 no extra samples", 32'(valid), 32'd0);
            @(negedge clk);
        end
        run_group(2'b10, "R10 counter once", 0);
    endtask

    task automatic t_wrap();
        for (int k = 0; k < 18; k++) run_group(2'b10, "R6 wrap", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_adc();
        t_rsvd();
        t_ident();
        t_midchange();
        t_busy();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule